// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block holds one 10-bit counter that climbs from zero to a selectable ceiling and then falls back to zero. The ceiling is 255, 511 or 1023. Two independent outputs, channel A and channel B, are produced from this shared counter. Each channel compares the counter against its own compare value. Depending on its mode, the channel drives a non-inverted or an inverted phase-correct PWM wave, or it leaves its output disconnected.

Compare values come in through a simple write port. A write lands in a per-channel shadow register. The value that the comparator uses is copied from the shadow only at the moment the counter arrives at its ceiling. Software can therefore change the duty at any time without producing a truncated or stretched pulse. The counter moves one step for each cycle in which the tick-enable input is high, so an external prescaler sets the PWM frequency.

Top module: `pwm_dual_slope`

## Requirements
- R1: On each tick the counter moves by exactly one toward the current endpoint. It reverses on the tick that lands it on TOP or on 0, so that each endpoint value is held for one tick. `dir_down_o` is 1 while counting down, and it is already 1 when the counter sits at TOP. One full cycle takes 2*TOP ticks, which is 510, 1022 or 2046 ticks.
- R2: `res_sel` = 00 gives a TOP of 255, 01 gives 511, and 10 or 11 gives 1023.
- R3: Mode 2'b10 gives non-inverted PWM. On the tick that lands the counter on the active compare value m, the output clears if the counter is then moving up and sets if it is moving down. In steady state the output is high for 2*m ticks of each cycle.
- R4: Mode 2'b11 gives inverted PWM. On such a tick the output sets if the counter is then moving up and clears if it is moving down. In steady state the output is high for 2*TOP-2*m ticks of each cycle.
- R5: Modes 2'b00 and 2'b01 drive the channel's `oe` low, and the channel's PWM output keeps its last value. Modes 10 and 11 drive `oe` high.
- R6: A compare write goes to the shadow register. The active compare value takes the shadow value only on the tick that lands the counter on TOP.
- R7: The duty reaches its extremes exactly. m = 0 gives 0 % in mode 10 and 100 % in mode 11, and m = TOP gives 100 % in mode 10 and 0 % in mode 11.
- R8: Channels A and B have separate shadow registers, active registers, modes and outputs. Their results do not depend on each other.
- R9: A synchronous reset sets the counter to 0 and the direction to up, and it clears the shadow values, active values, modes and outputs.
- R10: In a cycle without a tick, the counter, the direction and both PWM outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Counter step enable |
| res_sel | input | 2 | Resolution select (00: 8-bit, 01: 9-bit, 1x: 10-bit) |
| cmp_wr_a | input | 1 | Write `cmp_wdata` into channel A shadow |
| cmp_wr_b | input | 1 | Write `cmp_wdata` into channel B shadow |
| cmp_wdata | input | 10 | Compare value to write |
| mode_wr | input | 1 | Load both mode fields |
| mode_wdata_a | input | 2 | Channel A output mode |
| mode_wdata_b | input | 2 | Channel B output mode |
| cnt_o | output | 10 | Counter value |
| dir_down_o | output | 1 | Counting direction, 1 = down |
| pwm_a | output | 1 | Channel A PWM level |
| pwm_b | output | 1 | Channel B PWM level |
| oe_a | output | 1 | Channel A output enable |
| oe_b | output | 1 | Channel B output enable |

## Verification
The bench measures the steady-state high time per cycle for compare values of zero and TOP, for values one step from each endpoint, and for interior values, in both polarities and at all three resolutions. A design that evaluates the endpoint match against the wrong direction loses the 0 % and 100 % cases and instead shows glitch pulses one tick long. The bench also writes a compare value while the counter is falling. A design that passes writes straight through would clear the output early in the same cycle. The bench checks that a disconnected channel holds its level, and that the endpoint values last exactly one tick, since a design that dwells two ticks there would stretch the period.

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] res_sel,
  input  logic       cmp_wr_a,
  input  logic       cmp_wr_b,
  input  logic [9:0] cmp_wdata,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata_a,
  input  logic [1:0] mode_wdata_b,
  output logic [9:0] cnt_o,
  output logic       dir_down_o,
  output logic       pwm_a,
  output logic       pwm_b,
  output logic       oe_a,
  output logic       oe_b
);
  localparam int CW = 10;
  localparam int NCH = 2;

  logic [CW-1:0] cnt_q, cnt_nx, top_w;
  logic          dir_q, dir_nx, at_top_nx;

  assign top_w = (res_sel == 2'b00) ? 10'h0FF :
                 (res_sel == 2'b01) ? 10'h1FF : 10'h3FF;

  assign cnt_nx    = (dir_q || cnt_q >= top_w) ? cnt_q - 1'b1 : cnt_q + 1'b1;
  assign at_top_nx = (cnt_nx == top_w);
  assign dir_nx    = at_top_nx ? 1'b1 : (cnt_nx == '0) ? 1'b0 : dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_nx;
      dir_q <= dir_nx;
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_down_o = dir_q;

  logic [CW-1:0] shd_q [NCH];
  logic [CW-1:0] act_q [NCH];
  logic [1:0]    mode_q [NCH];
  logic          out_q [NCH];
  logic          wr_v [NCH];
  logic [1:0]    mdat_v [NCH];

  assign wr_v[0]   = cmp_wr_a;
  assign wr_v[1]   = cmp_wr_b;
  assign mdat_v[0] = mode_wdata_a;
  assign mdat_v[1] = mode_wdata_b;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] act_nx;
    logic          hit;

    assign act_nx = at_top_nx ? shd_q[i] : act_q[i];
    assign hit    = (cnt_nx == act_nx);

    always_ff @(posedge clk) begin
      if (rst) begin
        shd_q[i]  <= '0;
        act_q[i]  <= '0;
        mode_q[i] <= '0;
        out_q[i]  <= 1'b0;
      end else begin
        if (wr_v[i])  shd_q[i]  <= cmp_wdata;
        if (mode_wr)  mode_q[i] <= mdat_v[i];
        if (tick) begin
          act_q[i] <= act_nx;
          if (mode_q[i][1] && hit) out_q[i] <= mode_q[i][0] ^ dir_nx;
        end
      end
    end
  end

  assign pwm_a = out_q[0];
  assign pwm_b = out_q[1];
  assign oe_a  = mode_q[0][1];
  assign oe_b  = mode_q[1][1];
endmodule

module pwm_dual_slope_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [9:0] cnt_o,
  input logic       dir_down_o,
  input logic       pwm_a,
  input logic       pwm_b,
  input logic       oe_a,
  input logic       oe_b,
  input logic [9:0] top_w,
  input logic [9:0] act_a,
  input logic [9:0] act_b
);
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !rst) |=> ((cnt_o - $past(cnt_o) == 10'd1) || ($past(cnt_o) - cnt_o == 10'd1)));

  // R1
  zero_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == 10'd0) |-> !dir_down_o);

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !rst) |=> ($stable(cnt_o) && $stable(dir_down_o) && $stable(pwm_a) && $stable(pwm_b)));

  // R5
  disc_hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_a && !rst) |=> $stable(pwm_a));

  // R5
  disc_hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_b && !rst) |=> $stable(pwm_b));

  // R6
  commit_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && act_a != $past(act_a)) |-> (cnt_o == top_w));

  // R6
  commit_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && act_b != $past(act_b)) |-> (cnt_o == top_w));
endmodule

bind pwm_dual_slope pwm_dual_slope_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .cnt_o(cnt_o), .dir_down_o(dir_down_o),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .oe_a(oe_a), .oe_b(oe_b), .top_w(top_w),
  .act_a(act_q[0]), .act_b(act_q[1])
);

// File: tb/pwm_dual_slope_tb.sv
module pwm_dual_slope_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] res_sel = 2'b00;
  logic       cmp_wr_a = 1'b0, cmp_wr_b = 1'b0;
  logic [9:0] cmp_wdata = '0;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_wdata_a = '0, mode_wdata_b = '0;
  logic [9:0] cnt_o;
  logic       dir_down_o, pwm_a, pwm_b, oe_a, oe_b;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_dual_slope dut_i (.*);

  // {res, cmp_a, cmp_b, mode_a, mode_b, high_a, high_b}
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {2'd0, 10'd100,  10'd100, 2'b10, 2'b11, 11'd200,  11'd310},
    {2'd0, 10'd0,    10'd0,   2'b10, 2'b11, 11'd0,    11'd510},
    {2'd0, 10'd255,  10'd255, 2'b10, 2'b11, 11'd510,  11'd0},
    {2'd1, 10'd300,  10'd17,  2'b10, 2'b11, 11'd600,  11'd988},
    {2'd2, 10'd1023, 10'd512, 2'b11, 2'b10, 11'd0,    11'd1024},
    {2'd2, 10'd1,    10'd1000,2'b10, 2'b11, 11'd2,    11'd46},
    {2'd1, 10'd256,  10'd511, 2'b11, 2'b10, 11'd510,  11'd1022},
    {2'd0, 10'd1,    10'd254, 2'b11, 2'b10, 11'd508,  11'd508}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int top_of(input logic [1:0] r);
    return (r == 2'd0) ? 255 : (r == 2'd1) ? 511 : 1023;
  endfunction

  task automatic do_reset(input logic [1:0] r);
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; res_sel = r;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setup(input logic [9:0] a, input logic [9:0] b,
                       input logic [1:0] ma, input logic [1:0] mb);
    cmp_wdata = a; cmp_wr_a = 1'b1;
    @(negedge clk);
    cmp_wr_a = 1'b0; cmp_wdata = b; cmp_wr_b = 1'b1;
    @(negedge clk);
    cmp_wr_b = 1'b0;
    mode_wdata_a = ma; mode_wdata_b = mb; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    do_reset(2'd0);
    chk(cnt_o == 0 && !dir_down_o, "R9 counter", int'(cnt_o), 0);
    chk(!pwm_a && !pwm_b && !oe_a && !oe_b, "R9 outputs",
        int'({pwm_a, pwm_b, oe_a, oe_b}), 0);

    for (int v = 0; v < NV; v++) begin
      logic [47:0] e;
      int top, ha, hb;
      e = VEC[v];
      top = top_of(e[47:46]);
      do_reset(e[47:46]);
      setup(e[45:36], e[35:26], e[25:24], e[23:22]);
      chk(oe_a && oe_b, "R5 oe connected", int'({oe_a, oe_b}), 3);
      ticks(top);
      // R1 R2: at TOP after TOP ticks, already turned
      chk(int'(cnt_o) == top && dir_down_o, "R2 top value", int'(cnt_o), top);
      ticks(2 * top);
      chk(int'(cnt_o) == top, "R1 period", int'(cnt_o), top);
      ha = 0; hb = 0;
      tick = 1'b1;
      for (int k = 0; k < 2 * top; k++) begin
        @(negedge clk);
        ha += int'(pwm_a);
        hb += int'(pwm_b);
      end
      tick = 1'b0;
      // R3 R4 R7 R8: steady high time per cycle, per channel
      chk(ha == int'(e[21:11]), $sformatf("R3/R4/R7/R8 chA vec%0d", v), ha, int'(e[21:11]));
      chk(hb == int'(e[10:0]),  $sformatf("R3/R4/R7/R8 chB vec%0d", v), hb, int'(e[10:0]));
    end

    // R1: endpoint held exactly one tick
    do_reset(2'd0);
    ticks(255);
    ticks(1);
    chk(cnt_o == 10'd254 && dir_down_o, "R1 leave TOP", int'(cnt_o), 254);
    ticks(254);
    chk(cnt_o == 10'd0 && !dir_down_o, "R1 at zero", int'(cnt_o), 0);
    ticks(1);
    chk(cnt_o == 10'd1, "R1 leave zero", int'(cnt_o), 1);

    // R10: no tick, nothing moves
    begin
      logic [9:0] c0;
      c0 = cnt_o;
      repeat (20) @(negedge clk);
      chk(cnt_o == c0, "R10 hold", int'(cnt_o), int'(c0));
    end

    // R6: shadow write mid-cycle takes effect only after TOP
    do_reset(2'd0);
    setup(10'd100, 10'd0, 2'b10, 2'b00);
    ticks(255 + 510 + 205);
    chk(cnt_o == 10'd50 && dir_down_o, "R6 position", int'(cnt_o), 50);
    tick = 1'b1;
    cmp_wdata = 10'd20; cmp_wr_a = 1'b1;
    @(negedge clk);
    cmp_wr_a = 1'b0;
    while (!(cnt_o == 10'd60 && !dir_down_o)) @(negedge clk);
    chk(pwm_a == 1'b1, "R6 old value still active", int'(pwm_a), 1);
    while (cnt_o != 10'd255) @(negedge clk);
    while (!(cnt_o == 10'd60 && !dir_down_o)) @(negedge clk);
    chk(pwm_a == 1'b0, "R6 new value after TOP", int'(pwm_a), 0);

    // R5: disconnect holds level
    while (pwm_a != 1'b1) @(negedge clk);
    tick = 1'b0;
    mode_wdata_a = 2'b01; mode_wdata_b = 2'b00; mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    chk(!oe_a, "R5 oe low", int'(oe_a), 0);
    begin
      int drops;
      drops = 0;
      tick = 1'b1;
      repeat (600) begin
        @(negedge clk);
        if (pwm_a != 1'b1) drops++;
      end
      tick = 1'b0;
      chk(drops == 0, "R5 level held", drops, 0);
    end

    // R9: mid-run reset
    ticks(37);
    do_reset(2'd2);
    chk(cnt_o == 0 && !pwm_a && !oe_a && !dir_down_o, "R9 mid-run reset",
        int'(cnt_o), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule